// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of an SDRAM read or write burst. A controller presents a start column, a burst length code and an ordering choice together with a start pulse. From the next clock the block then issues one column address per cycle until the burst is complete. Fixed bursts of 1, 2, 4 or 8 beats are supported. They can use either sequential ordering (the low address bits count up and wrap) or interleaved ordering (the low bits are the start bits XORed with the beat index). A full-page burst walks the whole row in sequential order, wraps from the top column back to zero, and runs until it is stopped.

A stop input cuts any burst short. The block marks the final beat with a last flag, and pulses a done flag one cycle later. The controller uses these two flags to schedule precharge or the next column command. A new start is taken while the block is idle or on the final beat, so back-to-back bursts run with no idle cycle between them. Command encoding, bank and row tracking, refresh and read-data latency alignment are handled elsewhere.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: After reset is released, and before any start, valid_o, last_o and done_o are low and col_o is 0.
- R2: A start_i that is accepted at a clock edge makes valid_o high in the following cycle, with col_o equal to start_col_i as beat 0. One new beat is issued on each later clock.
- R3: The code bl_sel_i = 0, 1, 2 or 3 selects a burst of 1, 2, 4 or 8 beats. Any code of 4 or more selects full page. A burst that is not stopped holds valid_o high for exactly that many cycles.
- R4: Sequential ordering (interleave_i = 0): on beat k, the low log2(BL) bits of col_o equal (start + k) mod BL, and the upper bits equal those of the start column.
- R5: Interleaved ordering (interleave_i = 1): on beat k, the low log2(BL) bits of col_o equal the start bits XOR k, and the upper bits are unchanged.
- R6: A full-page burst always uses sequential order, whatever interleave_i is. It covers all 8 column bits, steps from column 255 to column 0, and runs until a stop arrives.
- R7: stop_i high during a valid beat makes that beat the last one: last_o is high in that same cycle, and valid_o is low in the next cycle unless a new start is accepted.
- R8: stop_i has no effect while no burst is running.
- R9: Without a stop, last_o is high only on beat BL-1 of a fixed-length burst. last_o is never high while valid_o is low.
- R10: done_o is high for exactly the one cycle that follows each cycle in which last_o is high.
- R11: A start_i during a beat that is not the last is ignored. A start_i on the last beat is accepted, and its beat 0 follows with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst with the settings sampled at this edge |
| start_col_i | input | 8 | Start column |
| bl_sel_i | input | 3 | Burst length code: 0..3 give 1/2/4/8 beats, 4 or more gives full page |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| stop_i | input | 1 | End the running burst on the current beat |
| valid_o | output | 1 | col_o holds a beat address |
| col_o | output | 8 | Column address of the current beat, 0 when idle |
| last_o | output | 1 | The current beat is the final one |
| done_o | output | 1 | Pulse in the cycle after the final beat |

## Verification
On every cycle, the embedded assertions check the following. last_o never appears without valid_o. A sequential burst advances its low bits by exactly one and keeps its upper bits fixed. A full-page burst steps the whole column by one, so the wrap from 255 to 0 is included. A stop ends the burst in the next cycle. The exact address sequence of interleaved bursts, the beat count for each length code, the placement of done_o, and the rule that an early start or an idle stop is ignored are shown only by the bench's scenarios. In those scenarios a behavioural model is compared with the outputs on every clock.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  // codes 0..N-1 select 2**code beats, anything above selects full page
  localparam int unsigned FIXED_BL_CODES = 4;

  function automatic int unsigned bl_log2(input int unsigned code);
    return (code < FIXED_BL_CODES) ? code : 0;
  endfunction
endpackage

// File: rtl/sdram_bl_decode.sv
module sdram_bl_decode
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COL_W    = 8,
  parameter int unsigned BL_SEL_W = 3
) (
  input  logic [BL_SEL_W-1:0] bl_sel_i,
  output logic [COL_W-1:0]    mask_o,
  output logic                full_o
);
  logic [31:0] log2_w;

  assign full_o = (32'(bl_sel_i) >= FIXED_BL_CODES);
  assign log2_w = bl_log2(32'(bl_sel_i));

  for (genvar i = 0; i < COL_W; i++) begin : g_mask
    assign mask_o[i] = full_o | (log2_w > i);
  end
endmodule

// File: rtl/sdram_beat_counter.sv
module sdram_beat_counter #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  output logic [COL_W-1:0] cnt_o,
  output logic             end_o
);
  logic [COL_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= '0;
    else if (adv_i)  cnt_q <= cnt_q + COL_W'(1);
  end

  assign cnt_o = cnt_q;
  // full page never ends on its own
  assign end_o = !full_i && (cnt_q == mask_i);
endmodule

// File: rtl/sdram_col_order.sv
module sdram_col_order #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] start_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             il_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum_w;

  assign sum_w = start_i + cnt_i;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col_o[i] = !mask_i[i] ? start_i[i]
                    : il_i      ? (start_i[i] ^ cnt_i[i])
                                : sum_w[i];
  end
endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen #(
  parameter int unsigned COL_W    = 8,
  parameter int unsigned BL_SEL_W = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [COL_W-1:0]    start_col_i,
  input  logic [BL_SEL_W-1:0] bl_sel_i,
  input  logic                interleave_i,
  input  logic                stop_i,
  output logic                valid_o,
  output logic [COL_W-1:0]    col_o,
  output logic                last_o,
  output logic                done_o
);
  logic             valid_q, done_q, full_q, il_q;
  logic [COL_W-1:0] start_q, mask_q;
  logic [COL_W-1:0] mask_w, cnt_w, col_w;
  logic             full_w, end_w, go_w, adv_w;

  sdram_bl_decode #(.COL_W(COL_W), .BL_SEL_W(BL_SEL_W)) u_dec (
    .bl_sel_i (bl_sel_i),
    .mask_o   (mask_w),
    .full_o   (full_w)
  );

  assign last_o = valid_q && (stop_i || end_w);
  assign go_w   = start_i && (!valid_q || last_o);
  assign adv_w  = valid_q && !last_o;

  sdram_beat_counter #(.COL_W(COL_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (go_w),
    .adv_i  (adv_w),
    .mask_i (mask_q),
    .full_i (full_q),
    .cnt_o  (cnt_w),
    .end_o  (end_w)
  );

  sdram_col_order #(.COL_W(COL_W)) u_ord (
    .start_i (start_q),
    .cnt_i   (cnt_w),
    .mask_i  (mask_q),
    .il_i    (il_q),
    .col_o   (col_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      start_q <= '0;
      mask_q  <= '0;
      full_q  <= 1'b0;
      il_q    <= 1'b0;
    end else begin
      done_q <= last_o;
      if (go_w) begin
        valid_q <= 1'b1;
        start_q <= start_col_i;
        mask_q  <= mask_w;
        full_q  <= full_w;
        il_q    <= interleave_i && !full_w; // full page is always sequential
      end else if (last_o) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign col_o   = valid_q ? col_w : '0;
  assign done_o  = done_q;

  AST_LAST_NEEDS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R9

  AST_STOP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && stop_i && !start_i) |=> !valid_o); // R7

  AST_UPPER_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> ((col_o & ~mask_q) == $past(col_o & ~mask_q))); // R4

  AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !il_q) |=>
      (((col_o - $past(col_o)) & mask_q) == (COL_W'(1) & mask_q))); // R4

  AST_FULL_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && full_q) |=> (col_o == $past(col_o) + COL_W'(1))); // R6
endmodule

// File: tb/sdram_col_burst_gen_tb.sv
module sdram_col_burst_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, il = 1'b0, stop = 1'b0;
  logic [7:0] scol = '0;
  logic [2:0] bsel = '0;
  logic       valid, last, done;
  logic [7:0] col;

  int vectors = 0, errors = 0;
  bit finished = 0;
  string req = "R1";

  // reference state
  bit m_act = 0, m_il = 0, m_done = 0;
  int m_start = 0, m_bl = 1, m_k = 0;

  always #2 clk = ~clk;

  sdram_col_burst_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .bl_sel_i(bsel), .interleave_i(il), .stop_i(stop),
    .valid_o(valid), .col_o(col), .last_o(last), .done_o(done)
  );

  function automatic int exp_col();
    int msk;
    if (!m_act) return 0;
    if (m_bl == 0) return (m_start + m_k) % 256;
    msk = m_bl - 1;
    if (m_il) return (m_start & ~msk & 255) | ((m_start ^ m_k) & msk);
    return (m_start & ~msk & 255) | ((m_start + m_k) & msk);
  endfunction

  function automatic bit exp_last();
    return m_act && (stop || (m_bl != 0 && m_k == m_bl - 1));
  endfunction

  task automatic chk(input string name, input int act, input int expv);
    vectors++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", req, name, act, expv, $time);
    end
  endtask

  task automatic cyc(input bit st, input int sc, input int bs, input bit ilv, input bit sp);
    bit lv;
    @(negedge clk);
    start = st; scol = 8'(sc); bsel = 3'(bs); il = ilv; stop = sp;
    #1;
    lv = exp_last();
    chk("valid_o", valid, m_act);
    chk("col_o", col, exp_col());
    chk("last_o", last, lv);
    chk("done_o", done, m_done);
    @(posedge clk);
    m_done = m_act && lv;
    if (st && (!m_act || lv)) begin
      m_act = 1; m_k = 0; m_start = sc;
      m_bl = (bs >= 4) ? 0 : (1 << bs);
      m_il = ilv && (bs < 4);
    end else if (m_act) begin
      if (lv) m_act = 0;
      else m_k = (m_k + 1) % 256;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask

  task automatic burst(input int sc, input int bs, input bit ilv);
    cyc(1, sc, bs, ilv, 0);
    idle((bs >= 4) ? 0 : (1 << bs) + 2);
  endtask

  initial begin
    // R1: reset values
    #7;
    req = "R1";
    chk("valid_o", valid, 0); chk("col_o", col, 0);
    chk("last_o", last, 0);   chk("done_o", done, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);

    req = "R2"; burst(8'h40, 0, 0);
    req = "R3"; burst(8'h13, 1, 0); burst(8'h27, 2, 0); burst(8'h10, 3, 0);
    req = "R4"; burst(8'hA6, 3, 0); burst(8'h5F, 2, 0);
    req = "R5"; burst(8'h05, 2, 1); burst(8'h3B, 3, 1); burst(8'hEE, 1, 1);
    req = "R9"; burst(8'h00, 3, 0);
    req = "R10"; burst(8'h81, 0, 1); burst(8'h82, 1, 0);

    // R6: full page, interleave request ignored, wrap 255->0
    req = "R6";
    cyc(1, 8'hFC, 7, 1, 0);
    idle(300);
    req = "R7"; cyc(0, 0, 0, 0, 1); idle(2);

    // R7: stop on beat 2 of an 8-beat burst
    cyc(1, 8'h30, 3, 0, 0); idle(2); cyc(0, 0, 0, 0, 1); idle(3);

    // R8: stop while idle
    req = "R8"; cyc(0, 0, 0, 0, 1); cyc(0, 0, 0, 0, 1); idle(1);
    burst(8'h44, 2, 0);

    // R11: start mid-burst ignored, start on last beat chained
    req = "R11";
    cyc(1, 8'h20, 2, 0, 0); cyc(1, 8'h99, 0, 0, 0); idle(1);
    cyc(0, 0, 0, 0, 0); cyc(1, 8'h51, 1, 1, 0);
    cyc(1, 8'h72, 0, 0, 0); cyc(1, 8'h73, 0, 0, 0);
    idle(3);
    // start together with stop: last beat, new burst follows
    cyc(1, 8'h10, 3, 1, 0); cyc(1, 8'hC8, 2, 0, 1); idle(6);

    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule